// File: doc/BRIEF.md
# Run-Length Configuration Stream Expander and Loader

This block sits between a clock-crossing FIFO that holds a compressed configuration stream and a 32-bit device configuration port. Each FIFO entry carries one 64-bit run value together with a repeat count and an end-of-stream marker. The block expands every run inline, splitting each 64-bit value into 32-bit port writes. It sustains one port write per clock while the FIFO keeps up. When the FIFO runs dry in the middle of a stream, it holds the port idle.

Once the final run has been written, the block plays a fixed command script. The script synchronises the port, issues a status-register read, turns the bus around for one read cycle, captures the returned status and then desynchronises the port. A masked compare of the captured status against a parameterised value gives the pass/fail result. That result comes out together with a one-cycle completion pulse. The FIFO is not read again until that pulse has been issued, so words of a following stream wait in the FIFO untouched.

Top module: `cfg_rle_loader`

## Requirements
- R1: After reset, port_en_n is 1, port_rd is 0, done is 0 and ok is 0, and no port cycle is issued while the FIFO is empty.
- R2: A FIFO word holds the run value in bits 63:0, the repeat count in bits 70:64 and the end-of-stream marker in bit 71. A count of n writes the run value n+1 times, so count 0 writes it once and count 127 writes it 128 times.
- R3: Each copy of a run value becomes two port writes (port_en_n = 0, port_rd = 0): bits 63:32 first, then bits 31:0.
- R4: Whenever the FIFO has no word ready in mid-stream, port_en_n stays 1 and no value is repeated or skipped.
- R5: Directly after the last data write, the port receives the writes FFFFFFFF, 000000BB, 11220044, FFFFFFFF, AA995566, 20000000, 2800E001, 20000000, 20000000, and after the status read it receives 30008001, 0000000D, 20000000, 20000000.
- R6: Exactly one read cycle (port_en_n = 0, port_rd = 1) occurs per stream. The cycle before it has port_rd = 1 with port_en_n = 1, and the cycle after it has port_rd = 0 with port_en_n = 1. port_rd only ever changes in a cycle where port_en_n is 1.
- R7: done is high for exactly one cycle per stream. In that cycle ok equals ((status & STAT_MASK) == STAT_EXPECT), where status is port_rdata sampled during the read cycle. ok holds that value until the next done.
- R8: No FIFO word is accepted between acceptance of the end-of-stream word and the done pulse. Accepting resumes after done.
- R9: With the FIFO never empty, done rises exactly D+16 cycles after the first data write, where D is the number of data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_data | input | 72 | Compressed word: marker, count, run value |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_ready | output | 1 | Block takes the word at this edge |
| port_en_n | output | 1 | Active-low configuration port enable |
| port_rd | output | 1 | 1 selects read, 0 selects write |
| port_wdata | output | 32 | Configuration write data |
| port_rdata | input | 32 | Configuration read data |
| done | output | 1 | One-cycle end-of-load pulse |
| ok | output | 1 | Status compare result, valid from done |

## Verification
The bench drives the repeat-count extremes: count 0 must give one copy, and count 127 must give 128. An off-by-one in the counter shows up as a changed write total. Mixed counts and periodic FIFO starvation catch an expander that repeats or drops a value across a stall, or that writes the halves in the wrong order. A second stream is preloaded behind the first. A design that does not lock its input would pull that stream's words in during the status script. Status values that differ only in unmasked bits, or only in masked bits, expose a compare that looks at the wrong bits. The check on bus turnaround order catches a read select that switches while the port is enabled.

// File: rtl/cfg_rle_pkg.sv
// Shared definitions for the run-length configuration loader.
// Holds the end-of-load command script as a computed step function.
// Assumes a 32-bit configuration port.
package cfg_rle_pkg;

    localparam int TAIL_LEN = 16;
    localparam int TAIL_IW  = $clog2(TAIL_LEN);

    typedef struct packed {
        logic        rd;    // read select driven to port
        logic        en_n;  // active-low enable driven to port
        logic        cap;   // sample port read data in this step
        logic [31:0] data;  // write data for this step
    } tail_step_t;

    // Returns the port drive for one step of the closing script.
    function automatic tail_step_t tail_step(input logic [TAIL_IW-1:0] idx);
        tail_step_t s;
        s = '{rd: 1'b0, en_n: 1'b0, cap: 1'b0, data: 32'h2000_0000};
        case (idx)
            4'd0, 4'd3: s.data = 32'hFFFF_FFFF;
            4'd1:       s.data = 32'h0000_00BB;
            4'd2:       s.data = 32'h1122_0044;
            4'd4:       s.data = 32'hAA99_5566;
            4'd6:       s.data = 32'h2800_E001;
            4'd9:       s = '{rd: 1'b1, en_n: 1'b1, cap: 1'b0, data: 32'h0};
            4'd10:      s = '{rd: 1'b1, en_n: 1'b0, cap: 1'b1, data: 32'h0};
            4'd11:      s = '{rd: 1'b0, en_n: 1'b1, cap: 1'b0, data: 32'h0};
            4'd12:      s.data = 32'h3000_8001;
            4'd13:      s.data = 32'h0000_000D;
            default:    s.data = 32'h2000_0000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rle_expander.sv
// Run expander: holds one compressed word and offers its value count+1
// times on a valid/ready output. Locks its input after accepting an
// end-of-stream word until release_i is pulsed.
// Assumes the word layout {marker, count, value}, marker in the MSB.
module rle_expander #(
    parameter int VAL_W = 64,
    parameter int CNT_W = 7,
    localparam int IN_W = VAL_W + CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [VAL_W-1:0] out_val,
    output logic             out_last,
    output logic             out_valid,
    input  logic             out_ready,
    input  logic             release_i
);

    logic [VAL_W-1:0] hold_val;
    logic [CNT_W-1:0] remain;
    logic             hold_last;
    logic             full;
    logic             locked;
    logic             take;
    logic             rep_done;
    logic             load;

    // Handshake terms for the holding register.
    always_comb begin
        take      = full && out_ready;
        rep_done  = (remain == '0);
        in_ready  = !locked && (!full || (take && rep_done));
        load      = in_valid && in_ready;
        out_val   = hold_val;
        out_valid = full;
        out_last  = hold_last && rep_done;
    end

    // Load a new run or count down copies of the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_val  <= '0;
            remain    <= '0;
            hold_last <= 1'b0;
            full      <= 1'b0;
            locked    <= 1'b0;
        end else begin
            if (load) begin
                hold_val  <= in_data[VAL_W-1:0];
                remain    <= in_data[VAL_W +: CNT_W];
                hold_last <= in_data[IN_W-1];
                full      <= 1'b1;
                if (in_data[IN_W-1]) begin
                    locked <= 1'b1;
                end
            end else if (take) begin
                if (rep_done) begin
                    full <= 1'b0;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
            if (release_i) begin
                locked <= 1'b0;
            end
        end
    end

    // R2: a held run keeps its value and count while not consumed.
    a_r2_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !out_ready) |=> ($stable(hold_val) && $stable(remain)));

endmodule

// File: rtl/word_splitter.sv
// Splits a wide run value into port-width slices, most significant slice
// first, one slice per accepted output cycle. Takes the next value in the
// same cycle it emits the final slice, so the output can stay busy.
// Assumes VAL_W is a whole multiple of PORT_W.
module word_splitter #(
    parameter int VAL_W  = 64,
    parameter int PORT_W = 32,
    localparam int SLICES = VAL_W / PORT_W,
    localparam int IDX_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  in_val,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [PORT_W-1:0] out_word,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);

    logic [VAL_W-1:0] sval;
    logic [IDX_W-1:0] idx;
    logic             slast;
    logic             full;
    logic             fire;
    logic             final_slice;

    // Select the current slice and compute handshakes.
    always_comb begin
        final_slice = (idx == IDX_W'(SLICES - 1));
        fire        = full && out_ready;
        in_ready    = !full || (fire && final_slice);
        out_valid   = full;
        out_word    = sval[VAL_W - 1 - int'(idx) * PORT_W -: PORT_W];
        out_last    = slast && final_slice;
    end

    // Advance the slice pointer or load the next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sval  <= '0;
            idx   <= '0;
            slast <= 1'b0;
            full  <= 1'b0;
        end else if (in_valid && in_ready) begin
            sval  <= in_val;
            slast <= in_last;
            idx   <= '0;
            full  <= 1'b1;
        end else if (fire) begin
            if (final_slice) begin
                full <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R3: an emitted non-final slice is followed by the next slice of the same value.
    a_r3_slice_order: assert property (@(posedge clk) disable iff (!rst_n)
        (full && out_ready && !final_slice) |=> (full && $stable(sval) && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/status_readback_seq.sv
// Closing script player: on start, drives the fixed sync / status-read /
// desync sequence onto the port, samples read data in the read step and
// raises a one-cycle done with the masked compare result.
// Assumes start is only pulsed while idle.
module status_readback_seq
    import cfg_rle_pkg::*;
#(
    parameter logic [31:0] STAT_MASK   = 32'h0000_5000,
    parameter logic [31:0] STAT_EXPECT = 32'h0000_4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] port_rdata,
    output logic        busy,
    output logic        seq_en_n,
    output logic        seq_rd,
    output logic [31:0] seq_wdata,
    output logic        done,
    output logic        ok
);

    logic [TAIL_IW-1:0] idx;
    logic [31:0]        status;
    tail_step_t         step;

    // Decode the current script step onto the port signals.
    always_comb begin
        step      = tail_step(idx);
        seq_en_n  = busy ? step.en_n : 1'b1;
        seq_rd    = busy ? step.rd : 1'b0;
        seq_wdata = step.data;
    end

    // Walk the script, sample status and issue the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            status <= '0;
            done   <= 1'b0;
            ok     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    idx  <= '0;
                end
            end else begin
                if (step.cap) begin
                    status <= port_rdata;
                end
                if (idx == TAIL_IW'(TAIL_LEN - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    ok   <= ((status & STAT_MASK) == STAT_EXPECT);
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R7: completion is a single-cycle pulse.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: ok only changes together with done.
    a_r7_ok_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ok));

endmodule

// File: rtl/cfg_rle_loader.sv
// Top of the run-length configuration loader. Chains the run expander and
// the slice splitter into a registered port stage, then hands the port to
// the closing script once the last slice has gone out.
// Assumes a 32-bit port and a FIFO that presents data with valid.
module cfg_rle_loader #(
    parameter int          VAL_W       = 64,
    parameter int          CNT_W       = 7,
    parameter int          PORT_W      = 32,
    parameter logic [31:0] STAT_MASK   = 32'h0000_5000,
    parameter logic [31:0] STAT_EXPECT = 32'h0000_4000,
    localparam int         IN_W        = VAL_W + CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   fifo_data,
    input  logic              fifo_valid,
    output logic              fifo_ready,
    output logic              port_en_n,
    output logic              port_rd,
    output logic [PORT_W-1:0] port_wdata,
    input  logic [PORT_W-1:0] port_rdata,
    output logic              done,
    output logic              ok
);

    logic [VAL_W-1:0]  run_val;
    logic              run_last;
    logic              run_valid;
    logic              run_ready;
    logic [PORT_W-1:0] split_word;
    logic              split_last;
    logic              split_valid;
    logic              split_ready;
    logic              seq_busy;
    logic              seq_en_n;
    logic              seq_rd;
    logic [31:0]       seq_wdata;
    logic              dp_en_n;
    logic [PORT_W-1:0] dp_wdata;
    logic              tail_go;

    rle_expander #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_expand (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (fifo_data),
        .in_valid  (fifo_valid),
        .in_ready  (fifo_ready),
        .out_val   (run_val),
        .out_last  (run_last),
        .out_valid (run_valid),
        .out_ready (run_ready),
        .release_i (done)
    );

    word_splitter #(.VAL_W(VAL_W), .PORT_W(PORT_W)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_val    (run_val),
        .in_last   (run_last),
        .in_valid  (run_valid),
        .in_ready  (run_ready),
        .out_word  (split_word),
        .out_last  (split_last),
        .out_valid (split_valid),
        .out_ready (split_ready)
    );

    status_readback_seq #(.STAT_MASK(STAT_MASK), .STAT_EXPECT(STAT_EXPECT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tail_go),
        .port_rdata (port_rdata[31:0]),
        .busy       (seq_busy),
        .seq_en_n   (seq_en_n),
        .seq_rd     (seq_rd),
        .seq_wdata  (seq_wdata),
        .done       (done),
        .ok         (ok)
    );

    // Data slices flow only while the script does not own the port.
    assign split_ready = !seq_busy;

    // Registered data stage: one write per slice, idle when none is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_en_n  <= 1'b1;
            dp_wdata <= '0;
            tail_go  <= 1'b0;
        end else begin
            dp_en_n <= !(split_valid && split_ready);
            if (split_valid && split_ready) begin
                dp_wdata <= split_word;
            end
            tail_go <= split_valid && split_ready && split_last;
        end
    end

    // Port ownership: the script while it runs, the data stage otherwise.
    always_comb begin
        port_en_n  = seq_busy ? seq_en_n : dp_en_n;
        port_rd    = seq_rd;
        port_wdata = seq_busy ? PORT_W'(seq_wdata) : dp_wdata;
    end

    // R6: the read select only changes while the port is disabled.
    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd != $past(port_rd)) |-> port_en_n);

    // R5: no data slice is pending while the closing script runs.
    a_r5_script_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !split_valid);

    // R8: no FIFO word is taken while the closing script runs.
    a_r8_no_pull_in_script: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !(fifo_valid && fifo_ready));

endmodule

// File: tb/cfg_rle_loader_tb.sv
module cfg_rle_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] fifo_data;
    logic        fifo_valid;
    logic        fifo_ready;
    logic        port_en_n;
    logic        port_rd;
    logic [31:0] port_wdata;
    logic [31:0] port_rdata = 32'h0;
    logic        done;
    logic        ok;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_rle_loader u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_data  (fifo_data),
        .fifo_valid (fifo_valid),
        .fifo_ready (fifo_ready),
        .port_en_n  (port_en_n),
        .port_rd    (port_rd),
        .port_wdata (port_wdata),
        .port_rdata (port_rdata),
        .done       (done),
        .ok         (ok)
    );

    // FIFO model
    logic [71:0] fmem [0:63];
    int unsigned f_wr = 0;
    int unsigned f_rd = 0;
    logic        stall_now = 1'b0;

    assign fifo_valid = (f_rd != f_wr) && !stall_now;
    assign fifo_data  = fmem[f_rd % 64];

    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && fifo_valid && fifo_ready) f_rd <= f_rd + 1;
        end
    end

    localparam logic [31:0] PRE [9] = '{32'hFFFF_FFFF, 32'h0000_00BB, 32'h1122_0044,
        32'hFFFF_FFFF, 32'hAA99_5566, 32'h2000_0000, 32'h2800_E001, 32'h2000_0000, 32'h2000_0000};
    localparam logic [31:0] POST [4] = '{32'h3000_8001, 32'h0000_000D, 32'h2000_0000, 32'h2000_0000};

    typedef struct packed {
        logic [7:0]  nw;
        logic [31:0] seed;
        logic [1:0]  cmode;
        logic [31:0] stat;
        logic        stall;
        logic        exp_ok;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd4, 32'h1234_5678, 2'd0, 32'h0000_4000, 1'b0, 1'b1},
        '{8'd6, 32'hCAFE_0001, 2'd1, 32'h0000_5000, 1'b0, 1'b0},
        '{8'd5, 32'h0BAD_F00D, 2'd3, 32'hABCD_4FFF, 1'b1, 1'b1},
        '{8'd3, 32'h5555_AAAA, 2'd1, 32'hFFFF_BFFF, 1'b1, 1'b0}
    };

    logic [31:0] exp_w [0:4199];
    int exp_n = 0;
    logic [1:0] ctrl_log [0:8191];

    function automatic logic [63:0] gen_val(input logic [31:0] seed, input int i);
        return {seed + 32'(i) * 32'h1111_1111, seed ^ (32'(i) * 32'h0F0F_0F0F + 32'd5)};
    endfunction

    function automatic int gen_cnt(input logic [1:0] cmode, input int i);
        case (cmode)
            2'd0:    return 0;
            2'd1:    return (i * 3) % 5;
            2'd2:    return (i == 0) ? 127 : 0;
            default: return (i % 2) ? 2 : 0;
        endcase
    endfunction

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push_stream(input int nw, input logic [31:0] seed, input logic [1:0] cmode);
        for (int i = 0; i < nw; i++) begin
            fmem[f_wr % 64] = {(i == nw - 1), 7'(gen_cnt(cmode, i)), gen_val(seed, i)};
            f_wr = f_wr + 1;
        end
    endtask

    task automatic build_exp(input int nw, input logic [31:0] seed, input logic [1:0] cmode);
        logic [63:0] v;
        exp_n = 0;
        for (int i = 0; i < nw; i++) begin
            v = gen_val(seed, i);
            for (int c = 0; c <= gen_cnt(cmode, i); c++) begin
                exp_w[exp_n] = v[63:32];
                exp_w[exp_n + 1] = v[31:0];
                exp_n += 2;
            end
        end
        for (int k = 0; k < 9; k++) begin exp_w[exp_n] = PRE[k]; exp_n++; end
        for (int k = 0; k < 4; k++) begin exp_w[exp_n] = POST[k]; exp_n++; end
    endtask

    task automatic observe(input int nw, input logic [31:0] stat, input bit stall, input bit exp_ok);
        int cyc = 0;
        int nwr = 0;
        int first = -1;
        int donec = -1;
        int nrd = 0;
        int rdc = -1;
        int hs = 0;
        int lockv = 0;
        int mism = -1;
        logic [31:0] mact = '0;
        logic ok_at_done = 1'b0;
        port_rdata = stat;
        while (donec < 0 && cyc < 8000) begin
            @(negedge clk);
            ctrl_log[cyc] = {port_rd, port_en_n};
            if (!port_en_n && !port_rd) begin
                if (first < 0) first = cyc;
                if (mism < 0 && (nwr >= exp_n || port_wdata != exp_w[nwr])) begin
                    mism = nwr;
                    mact = port_wdata;
                end
                nwr++;
            end
            if (!port_en_n && port_rd) begin
                nrd++;
                rdc = cyc;
            end
            if (fifo_valid && fifo_ready) begin
                if (hs >= nw) lockv++;
                hs++;
            end
            if (done) begin
                donec = cyc;
                ok_at_done = ok;
            end
            stall_now = stall && (cyc % 5 == 2);
            cyc++;
        end
        stall_now = 1'b0;
        chk(donec >= 0, "R7", "done reached", 32'(donec), 32'd0);
        chk(nwr == exp_n, "R2", "write count", 32'(nwr), 32'(exp_n));
        chk(mism < 0, stall ? "R4" : "R3", $sformatf("write data at %0d", mism), mact,
            (mism >= 0 && mism < exp_n) ? exp_w[mism] : 32'h0);
        chk(nrd == 1, "R6", "read cycles", 32'(nrd), 32'd1);
        if (rdc > 0) begin
            chk(ctrl_log[rdc - 1] == 2'b11, "R6", "ctrl before read", 32'(ctrl_log[rdc - 1]), 32'd3);
            chk(ctrl_log[rdc + 1] == 2'b01, "R6", "ctrl after read", 32'(ctrl_log[rdc + 1]), 32'd1);
        end
        chk(ok_at_done == exp_ok, "R7", "ok at done", 32'(ok_at_done), 32'(exp_ok));
        chk(lockv == 0, "R8", "fifo pulls during lock", 32'(lockv), 32'd0);
        if (!stall) chk(donec - first == exp_n + 3, "R9", "done latency", 32'(donec - first), 32'(exp_n + 3));
        @(negedge clk);
        chk(done == 1'b0, "R7", "done width", 32'(done), 32'd0);
        chk(ok == exp_ok, "R7", "ok held", 32'(ok), 32'(exp_ok));
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(port_en_n == 1'b1, "R1", "en_n in reset", 32'(port_en_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(port_en_n == 1'b1 && port_rd == 1'b0, "R1", "port after reset",
            {30'd0, port_rd, port_en_n}, 32'd1);
        chk(done == 1'b0 && ok == 1'b0, "R1", "done/ok after reset", {30'd0, done, ok}, 32'd0);
        begin
            int act = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!port_en_n) act++;
            end
            chk(act == 0, "R1", "idle with empty fifo", 32'(act), 32'd0);
        end

        // table-driven streams
        for (int v = 0; v < 4; v++) begin
            push_stream(int'(VECS[v].nw), VECS[v].seed, VECS[v].cmode);
            build_exp(int'(VECS[v].nw), VECS[v].seed, VECS[v].cmode);
            observe(int'(VECS[v].nw), VECS[v].stat, VECS[v].stall, VECS[v].exp_ok);
        end

        // R2 minimum: single word, count 0
        push_stream(1, 32'h0F1E_2D3C, 2'd0);
        build_exp(1, 32'h0F1E_2D3C, 2'd0);
        observe(1, 32'h0000_4000, 1'b0, 1'b1);

        // R2 maximum: count 127 gives 128 copies
        push_stream(2, 32'h7777_0000, 2'd2);
        build_exp(2, 32'h7777_0000, 2'd2);
        observe(2, 32'h0000_4000, 1'b0, 1'b1);

        // R8: a second stream waits in the FIFO during the first one's script
        push_stream(3, 32'h1357_9BDF, 2'd3);
        push_stream(2, 32'h2468_ACE0, 2'd0);
        build_exp(3, 32'h1357_9BDF, 2'd3);
        observe(3, 32'h0000_4000, 1'b0, 1'b1);
        build_exp(2, 32'h2468_ACE0, 2'd0);
        observe(2, 32'h0000_1000, 1'b0, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule